// File: doc/BRIEF.md
# Crossbar Write Pulse Sequencer

This block times one write operation on a resistive crossbar array. On a start command it first holds the unselected word and bit lines at half the write voltage. Once that precharge has settled, it closes the strobing switch so that the full write voltage reaches the selected word line for a programmed number of ticks. Finally it runs a short discharge phase that takes the array back to ground. One clock cycle is one timing tick, which is 3.2 ns in the intended system.

In burst mode the array is precharged once. The strobe then fires several times, and a programmed gap separates successive strobes. The half-voltage drive stays on through every gap. The precharge length, pulse width, gap and pulse count come from configuration inputs, which are sampled when the start command is accepted. Each value is clamped to a safe floor. The minimum precharge makes a single-pulse operation last at least 1.55 µs, and the minimum pulse width corresponds to a 30 ns nominal pulse.

Top module: `xbar_wpulse_seq`

## Requirements
- R1: After reset, `busy`, `half_drive`, `strobe` and `discharge` are all low.
- R2: When `start` is high while idle, from the next cycle `busy` and `half_drive` are high and `strobe` is low for max(`cfg_pre`, MIN_PRE) cycles (MIN_PRE defaults to 472).
- R3: `strobe` rises only after a precharge, and `half_drive` stays high during every strobe. Each strobe lasts the effective width.
- R4: After the last strobe, `discharge` is high for RTG_TICKS cycles (default 4) with `half_drive` and `strobe` low. Then all outputs return low.
- R5: With `cfg_burst`=1, exactly `cfg_count` strobes follow a single precharge. Between strobes, gaps of max(`cfg_gap`, 1) cycles keep `half_drive` high and `strobe` low.
- R6: A `cfg_count` of zero yields one strobe. With `cfg_burst`=0, exactly one strobe occurs whatever `cfg_count` is.
- R7: The effective width is max(`cfg_width`, MIN_WIDTH), with MIN_WIDTH defaulting to 10 ticks.
- R8: A `start` that arrives while `busy` is high is ignored. Configuration changes made while busy do not affect the running operation.
- R9: `busy` is high exactly from the cycle after the accepted start to the last discharge cycle. No output is active while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one write operation when idle |
| cfg_pre | input | TICK_W | Precharge length in ticks |
| cfg_width | input | TICK_W | Strobe width in ticks |
| cfg_gap | input | TICK_W | Gap between burst strobes in ticks |
| cfg_count | input | CNT_W | Number of strobes in burst mode |
| cfg_burst | input | 1 | 1 selects burst mode |
| busy | output | 1 | Operation in progress |
| half_drive | output | 1 | Drive unselected lines to half voltage |
| strobe | output | 1 | Strobing switch closed |
| discharge | output | 1 | Return array to ground |

## Verification
The scoreboard reduces the outputs to a run-length list of phases (half-drive only, strobe, discharge) and compares it with a list computed from the clamp rules. Several patterns are applied:
- A single pulse with its configuration above the floors tests the plain timing.
- Undersized precharge, width and gap values separate a clamped result from a raw one.
- Burst runs with counts of three, zero and two, plus a run with burst off and a nonzero count, separate a single precharge with repeated strobes from repeated full operations.
- A start pulse and a configuration change in the middle of a burst show whether the sampled settings are held.

// File: rtl/xbar_wseq_pkg.sv
package xbar_wseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_PULSE = 3'd2,
        ST_GAP   = 3'd3,
        ST_RTG   = 3'd4
    } wseq_state_e;
endpackage

// File: rtl/wseq_clamp.sv
module wseq_clamp #(
    parameter int TICK_W    = 16,
    parameter int CNT_W     = 8,
    parameter int MIN_PRE   = 472,
    parameter int MIN_WIDTH = 10
) (
    input  logic [TICK_W-1:0] raw_pre,
    input  logic [TICK_W-1:0] raw_width,
    input  logic [TICK_W-1:0] raw_gap,
    input  logic [CNT_W-1:0]  raw_count,
    input  logic              burst,
    output logic [TICK_W-1:0] pre_len,
    output logic [TICK_W-1:0] width_len,
    output logic [TICK_W-1:0] gap_len,
    output logic [CNT_W-1:0]  n_pulses
);
    localparam logic [TICK_W-1:0] PRE_FLOOR   = TICK_W'(MIN_PRE);
    localparam logic [TICK_W-1:0] WIDTH_FLOOR = TICK_W'(MIN_WIDTH);
    localparam logic [TICK_W-1:0] GAP_FLOOR   = TICK_W'(1);
    localparam logic [CNT_W-1:0]  ONE_PULSE   = CNT_W'(1);

    always_comb begin
        pre_len   = (raw_pre   < PRE_FLOOR)   ? PRE_FLOOR   : raw_pre;
        width_len = (raw_width < WIDTH_FLOOR) ? WIDTH_FLOOR : raw_width;
        gap_len   = (raw_gap   < GAP_FLOOR)   ? GAP_FLOOR   : raw_gap;
        n_pulses  = (!burst || raw_count == '0) ? ONE_PULSE : raw_count;
    end
endmodule

// File: rtl/wseq_timer.sv
module wseq_timer #(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TICK_W-1:0] load_val,
    output logic              expired
);
    logic [TICK_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/wseq_pulse_ctr.sv
module wseq_pulse_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load)
            rem_d = load_val;
        else if (dec && rem_q != '0)
            rem_d = rem_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    assign last = (rem_q == '0);
endmodule

// File: rtl/xbar_wpulse_seq.sv
module xbar_wpulse_seq
    import xbar_wseq_pkg::*;
#(
    parameter int TICK_W     = 16,
    parameter int CNT_W      = 8,
    parameter int MIN_PRE    = 472,
    parameter int MIN_WIDTH  = 10,
    parameter int RTG_TICKS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TICK_W-1:0] cfg_pre,
    input  logic [TICK_W-1:0] cfg_width,
    input  logic [TICK_W-1:0] cfg_gap,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_burst,
    output logic              busy,
    output logic              half_drive,
    output logic              strobe,
    output logic              discharge
);
    localparam logic [TICK_W-1:0] RTG_LOAD = TICK_W'(RTG_TICKS - 1);

    typedef struct packed {
        wseq_state_e       st;
        logic [TICK_W-1:0] width;
        logic [TICK_W-1:0] gap;
        logic              busy;
        logic              half;
        logic              strobe;
        logic              disc;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [TICK_W-1:0] cl_pre, cl_width, cl_gap;
    logic [CNT_W-1:0]  cl_n;
    logic              tmr_load, tmr_done;
    logic [TICK_W-1:0] tmr_val;
    logic              pc_load, pc_dec, pc_last;
    logic [CNT_W-1:0]  pc_val;

    wseq_clamp #(
        .TICK_W(TICK_W), .CNT_W(CNT_W),
        .MIN_PRE(MIN_PRE), .MIN_WIDTH(MIN_WIDTH)
    ) u_clamp (
        .raw_pre(cfg_pre), .raw_width(cfg_width), .raw_gap(cfg_gap),
        .raw_count(cfg_count), .burst(cfg_burst),
        .pre_len(cl_pre), .width_len(cl_width), .gap_len(cl_gap),
        .n_pulses(cl_n)
    );

    wseq_timer #(.TICK_W(TICK_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_done)
    );

    wseq_pulse_ctr #(.CNT_W(CNT_W)) u_pctr (
        .clk(clk), .rst_n(rst_n), .load(pc_load),
        .load_val(pc_val), .dec(pc_dec), .last(pc_last)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        pc_load  = 1'b0;
        pc_val   = '0;
        pc_dec   = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_PRE;
                    r_d.width = cl_width;
                    r_d.gap   = cl_gap;
                    tmr_load  = 1'b1;
                    tmr_val   = cl_pre - 1'b1;
                    pc_load   = 1'b1;
                    pc_val    = cl_n - 1'b1;
                end
            end
            ST_PRE: begin
                if (tmr_done) begin
                    r_d.st   = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = r_q.width - 1'b1;
                end
            end
            ST_PULSE: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (pc_last) begin
                        r_d.st  = ST_RTG;
                        tmr_val = RTG_LOAD;
                    end else begin
                        r_d.st  = ST_GAP;
                        tmr_val = r_q.gap - 1'b1;
                        pc_dec  = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_done) begin
                    r_d.st   = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = r_q.width - 1'b1;
                end
            end
            ST_RTG: begin
                if (tmr_done)
                    r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        r_d.busy   = (r_d.st != ST_IDLE);
        r_d.half   = (r_d.st == ST_PRE) || (r_d.st == ST_PULSE) || (r_d.st == ST_GAP);
        r_d.strobe = (r_d.st == ST_PULSE);
        r_d.disc   = (r_d.st == ST_RTG);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.width  <= '0;
            r_q.gap    <= '0;
            r_q.busy   <= 1'b0;
            r_q.half   <= 1'b0;
            r_q.strobe <= 1'b0;
            r_q.disc   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = r_q.busy;
    assign half_drive = r_q.half;
    assign strobe     = r_q.strobe;
    assign discharge  = r_q.disc;
endmodule

// File: rtl/xbar_wseq_chk.sv
module xbar_wseq_chk #(
    parameter int TICK_W    = 16,
    parameter int MIN_WIDTH = 10
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic half_drive,
    input logic strobe,
    input logic discharge
);
    logic [TICK_W:0] srun_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     srun_q <= '0;
        else if (strobe) srun_q <= srun_q + 1'b1;
        else             srun_q <= '0;
    end

    // R3
    strobe_needs_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> half_drive);

    // R3
    strobe_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(half_drive));

    // R4
    ground_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discharge |-> (!half_drive && !strobe));

    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(discharge));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(half_drive || strobe || discharge));

    // R7
    min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> (srun_q >= (TICK_W+1)'(MIN_WIDTH)));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !discharge) |=> busy);
endmodule

bind xbar_wpulse_seq xbar_wseq_chk #(.TICK_W(TICK_W), .MIN_WIDTH(MIN_WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .half_drive(half_drive),
    .strobe(strobe), .discharge(discharge)
);

// File: tb/tb_xbar_wpulse_seq.sv
module tb_xbar_wpulse_seq;
    localparam int TICK_W = 16;
    localparam int CNT_W  = 8;
    localparam int MIN_PRE = 472;
    localparam int MIN_W   = 10;
    localparam int RTG     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [TICK_W-1:0] cfg_pre = '0, cfg_width = '0, cfg_gap = '0;
    logic [CNT_W-1:0]  cfg_count = '0;
    logic cfg_burst = 1'b0;
    logic busy, half_drive, strobe, discharge;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int    q_code[$];
    int    q_len[$];
    string q_tag[$];

    always #4 clk = ~clk;

    xbar_wpulse_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_pre(cfg_pre), .cfg_width(cfg_width), .cfg_gap(cfg_gap),
        .cfg_count(cfg_count), .cfg_burst(cfg_burst),
        .busy(busy), .half_drive(half_drive), .strobe(strobe), .discharge(discharge)
    );

    function automatic int phase_code();
        if (discharge)  return 3;
        if (strobe)     return 2;
        if (half_drive) return 1;
        return 0;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(int code, int len, string tag);
        q_code.push_back(code);
        q_len.push_back(len);
        q_tag.push_back(tag);
    endtask

    // monitor: run-length compare of output phases against the scoreboard
    int cur_code = 0;
    int run_len  = 0;
    bit busy_ok  = 1;
    always @(negedge clk) begin
        if (rst_n) begin
            int c;
            c = phase_code();
            if (c != cur_code) begin
                if (cur_code != 0) begin
                    if (q_code.size() == 0) begin
                        check(0, "R8", "unexpected phase", cur_code, 0);
                    end else begin
                        int ec, el;
                        string et;
                        ec = q_code.pop_front();
                        el = q_len.pop_front();
                        et = q_tag.pop_front();
                        check(ec == cur_code, et, "phase code", cur_code, ec);
                        check(el == run_len, et, "phase length", run_len, el);
                        check(busy_ok, "R9", "busy during phase", 0, 1);
                    end
                end
                cur_code = c;
                run_len  = 1;
                busy_ok  = (busy == (c != 0));
            end else begin
                run_len++;
                if (busy != (c != 0)) busy_ok = 0;
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_op(int pre, int width, int gap, int count, bit burst, string tag);
        int n;
        @(negedge clk);
        cfg_pre = TICK_W'(pre); cfg_width = TICK_W'(width); cfg_gap = TICK_W'(gap);
        cfg_count = CNT_W'(count); cfg_burst = burst;
        start = 1'b1;
        n = (!burst || count == 0) ? 1 : count;
        push(1, imax(pre, MIN_PRE), tag);
        for (int i = 0; i < n; i++) begin
            push(2, imax(width, MIN_W), tag);
            if (i != n - 1) push(1, imax(gap, 1), tag);
        end
        push(3, RTG, "R4");
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!busy && !half_drive && !strobe && !discharge, "R1", "reset outputs",
              {busy, half_drive, strobe, discharge}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy, "R1", "idle after reset", busy, 0);

        // R2/R3 single pulse, values above floors
        run_op(500, 20, 0, 0, 0, "R2");
        check(busy && half_drive && !strobe, "R2", "precharge started", {busy, half_drive, strobe}, 6);
        wait_idle();

        // R7 clamp width, R2 clamp precharge
        run_op(10, 3, 0, 0, 0, "R7");
        wait_idle();

        // R5 burst of three
        run_op(480, 12, 7, 3, 1, "R5");
        wait_idle();

        // R6 count zero in burst mode
        run_op(472, 15, 5, 0, 1, "R6");
        wait_idle();

        // R6 burst off ignores count
        run_op(473, 11, 5, 5, 0, "R6");
        wait_idle();

        // R5 gap zero clamped to one
        run_op(472, 10, 0, 2, 1, "R5");
        wait_idle();

        // R8 start and config change while busy
        run_op(490, 15, 6, 2, 1, "R8");
        repeat (100) @(negedge clk);
        cfg_width = 16'd60; cfg_gap = 16'd30; cfg_count = 8'd9;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        check(!busy, "R8", "no restart after ignored start", busy, 0);
        check(q_code.size() == 0, "R9", "scoreboard drained", q_code.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog expired: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule